// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a watchdog timer that issues a one-cycle reset pulse when its counter chain runs out. It counts ticks from one of three sources. Two are enable ticks from outside the block: a dedicated slow oscillator and a real-time clock. The third is the system clock divided by four inside the block. The chosen tick stream goes first through an 8-bit divide-by-256 stage and then through a prescaler. The prescaler ratio is 2 to the power of a 3-bit select value, so it ranges from 1:1 to 1:128.

The watchdog can be switched on in two ways: by a configuration input, or by a 4-bit key register that software writes through a load strobe. It is off only when the key holds the single disable code and the configuration input is also low. While it is off, the counters hold their value and the clear strobe does nothing. The active flag tells the rest of the chip whether watchdog instructions take effect or act as no-ops. During power-down the system clock stops, so the divided system-clock source stops counting as well. The two external tick sources keep running.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the key register holds 4'b1010, so with `cfg_en` low `wdt_active` reads 0.
- R2: `wdt_active` is 1 whenever `cfg_en` is 1 or the key register differs from 4'b1010. Loading 4'b0101 or any other code except 4'b1010 activates the watchdog.
- R3: `src_sel` 0 counts `osc_tick`, 1 counts `rtc_tick`, and 2 or 3 counts one tick every fourth `clk` cycle. Ticks on a source that is not selected have no effect.
- R4: Counting from cleared counters, `wdt_rst` pulses in the cycle after the (256 × 2^`ratio_sel`)-th selected tick.
- R5: `wdt_rst` is high for exactly one cycle. The chain restarts from zero, so the next timeout again takes the full count.
- R6: A `clr` pulse while active zeroes both counter stages, and it takes priority over a tick in the same cycle.
- R7: While inactive, the counters hold their value and `clr` is ignored. Counting resumes from the held value once the watchdog is active again.
- R8: While `pdown` is 1, the divided system-clock source produces no ticks. The oscillator and RTC sources still count.
- R9: `wdt_rst` never pulses while the watchdog is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Configuration enable, forces the watchdog on |
| src_sel | input | 2 | Tick source: 0 oscillator, 1 RTC, 2/3 clk/4 |
| osc_tick | input | 1 | One-cycle tick from the dedicated oscillator |
| rtc_tick | input | 1 | One-cycle tick from the real-time clock |
| key_load | input | 1 | Write strobe for the key register |
| key_data | input | 4 | Key value to load |
| ratio_sel | input | 3 | Prescaler select, ratio 2^value |
| clr | input | 1 | Clears the counter chain while active |
| pdown | input | 1 | Power-down indication, stops the clk/4 source |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| wdt_active | output | 1 | Watchdog enabled flag |

## Verification
The bench measures the exact tick on which the reset fires at the smallest, a middle and the largest prescaler ratio. A prescaler compare that is off by one would fire 256 ticks early or late. It clears the chain partway through a count and checks that the next timeout takes the full length. It then clears while disabled and checks that the timeout, once the watchdog is enabled again, is only the remainder. A design that resets on disable or obeys that clear would fire late. It also checks that the unselected source has no effect, and that the clk/4 source stops during power-down while the oscillator source does not. A design with the gating wrong would either never time out or reset the device while it sleeps. Random tick and clear traffic on both external sources is compared with a tick-count model, cycle by cycle.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 7,
  parameter int SEL_W = 3,
  parameter int KEY_W = 4,
  parameter logic [KEY_W-1:0] OFF_KEY = 4'b1010,
  parameter int SYS_DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [1:0]       src_sel,
  input  logic             osc_tick,
  input  logic             rtc_tick,
  input  logic             key_load,
  input  logic [KEY_W-1:0] key_data,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             clr,
  input  logic             pdown,
  output logic             wdt_rst,
  output logic             wdt_active
);
  localparam int LIM_W = PRE_W + 1;

  logic [KEY_W-1:0]     key_q;
  logic [SYS_DIV_W-1:0] sys_q;
  logic [DIV_W-1:0]     div_q;
  logic [PRE_W-1:0]     pre_q;
  logic [LIM_W-1:0]     pre_lim;
  logic                 sys_tick, tick, div_wrap, fire;

  assign wdt_active = cfg_en || (key_q != OFF_KEY);
  assign sys_tick   = !pdown && (&sys_q);
  assign div_wrap   = &div_q;
  assign pre_lim    = (LIM_W'(1) << ratio_sel) - LIM_W'(1);
  assign fire       = wdt_active && !clr && tick && div_wrap && ({1'b0, pre_q} >= pre_lim);

  always_comb begin
    case (src_sel)
      2'd0:    tick = osc_tick;
      2'd1:    tick = rtc_tick;
      default: tick = sys_tick;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= OFF_KEY;
      sys_q <= '0;
    end else begin
      if (key_load) key_q <= key_data;
      if (!pdown)   sys_q <= sys_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      pre_q   <= '0;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= fire;
      if (wdt_active) begin
        if (clr || fire) begin
          div_q <= '0;
          pre_q <= '0;
        end else if (tick) begin
          div_q <= div_q + 1'b1;
          if (div_wrap) pre_q <= pre_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 7,
  parameter int KEY_W = 4,
  parameter logic [KEY_W-1:0] OFF_KEY = 4'b1010
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_rst,
  input logic             wdt_active,
  input logic             pdown,
  input logic             clr,
  input logic [1:0]       src_sel,
  input logic             key_load,
  input logic [KEY_W-1:0] key_data,
  input logic [DIV_W-1:0] div_q,
  input logic [PRE_W-1:0] pre_q
);
  assert_key_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && key_data != OFF_KEY) |=> wdt_active);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (div_q == '0 && pre_q == '0));

  assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wdt_active) |=> (div_q == '0 && pre_q == '0));

  assert_frozen_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_active |=> ($stable(div_q) && $stable(pre_q)));

  assert_sys_pdown_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && src_sel[1] && !clr) |=> ($stable(div_q) && $stable(pre_q)));

  assert_no_reset_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_active |=> !wdt_rst);
endmodule

bind keyed_watchdog keyed_watchdog_chk #(
  .DIV_W(DIV_W), .PRE_W(PRE_W), .KEY_W(KEY_W), .OFF_KEY(OFF_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .wdt_active(wdt_active),
  .pdown(pdown), .clr(clr), .src_sel(src_sel), .key_load(key_load),
  .key_data(key_data), .div_q(div_q), .pre_q(pre_q)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, osc_tick = 0, rtc_tick = 0, key_load = 0, clr = 0, pdown = 0;
  logic [1:0] src_sel = 0;
  logic [3:0] key_data = 0;
  logic [2:0] ratio_sel = 0;
  logic wdt_rst, wdt_active;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .src_sel(src_sel),
    .osc_tick(osc_tick), .rtc_tick(rtc_tick), .key_load(key_load),
    .key_data(key_data), .ratio_sel(ratio_sel), .clr(clr), .pdown(pdown),
    .wdt_rst(wdt_rst), .wdt_active(wdt_active)
  );

  function automatic int timeout_ticks(int sel);
    return 256 << sel;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_key(logic [3:0] k);
    key_load = 1; key_data = k;
    @(posedge clk); @(negedge clk);
    key_load = 0;
  endtask

  task automatic pulse_clr();
    clr = 1;
    @(posedge clk); @(negedge clk);
    clr = 0;
  endtask

  // which: 0 osc, 1 rtc, 2 no tick (idle cycles); returns first firing index, 0 if none
  task automatic run(int which, int n, output int first);
    first = 0;
    for (int i = 1; i <= n; i++) begin
      osc_tick = (which == 0);
      rtc_tick = (which == 1);
      @(posedge clk); @(negedge clk);
      if (wdt_rst && first == 0) first = i;
    end
    osc_tick = 0; rtc_tick = 0;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f, cnt, lim, exp_rst;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 active after reset", wdt_active, 0);
    chk("R1 rst after reset", wdt_rst, 0);

    run(0, 300, f);
    chk("R9 disabled no reset", f, 0);

    load_key(4'b0101);
    chk("R2 key 0101 active", wdt_active, 1);
    load_key(4'b1010); cfg_en = 1; #1;
    chk("R2 cfg overrides key", wdt_active, 1);
    cfg_en = 0; #1;
    chk("R2 off code and cfg low", wdt_active, 0);
    load_key(4'b0011);
    chk("R2 other key active", wdt_active, 1);

    ratio_sel = 0; pulse_clr();
    run(0, 300, f);
    chk("R4 sel0 timeout", f, timeout_ticks(0));
    pulse_clr();
    run(0, 256, f);
    chk("R5 full count again", f, 256);
    run(2, 1, f);
    chk("R5 one cycle pulse", wdt_rst, 0);
    run(0, 256, f);
    chk("R5 restart from zero", f, 256);

    ratio_sel = 3; pulse_clr();
    run(0, 2100, f);
    chk("R4 sel3 timeout", f, timeout_ticks(3));
    ratio_sel = 7; pulse_clr();
    run(0, 33000, f);
    chk("R4 sel7 timeout", f, timeout_ticks(7));

    ratio_sel = 0; pulse_clr();
    run(0, 200, f);
    pulse_clr();
    run(0, 300, f);
    chk("R6 clear restarts count", f, 256);
    pulse_clr();
    run(0, 255, f);
    clr = 1; osc_tick = 1;
    @(posedge clk); @(negedge clk);
    clr = 0; osc_tick = 0;
    chk("R6 clear beats tick", wdt_rst, 0);
    run(0, 300, f);
    chk("R6 after clear vs tick", f, 256);

    pulse_clr();
    run(0, 100, f);
    load_key(4'b1010);
    pulse_clr();
    run(0, 500, f);
    chk("R7 frozen while inactive", f, 0);
    load_key(4'b0101);
    run(0, 300, f);
    chk("R7 resume from held count", f, 156);

    src_sel = 1; pulse_clr();
    run(0, 300, f);
    chk("R3 osc ignored on rtc source", f, 0);
    run(1, 300, f);
    chk("R3 rtc source timeout", f, 256);

    src_sel = 2; pulse_clr();
    run(2, 1100, f);
    chk("R3 clk4 timeout low bound", int'(f >= 1020), 1);
    chk("R3 clk4 timeout high bound", int'(f <= 1028), 1);
    pdown = 1; pulse_clr();
    run(2, 3000, f);
    chk("R8 clk4 stops in power down", f, 0);
    src_sel = 0; pulse_clr();
    run(0, 300, f);
    chk("R8 osc counts in power down", f, 256);
    pdown = 0;

    cnt = 0; lim = 256; exp_rst = 0;
    for (int blk = 0; blk < 8; blk++) begin
      src_sel = 2'($urandom_range(0, 1));
      ratio_sel = 3'($urandom_range(0, 2));
      lim = timeout_ticks(int'(ratio_sel));
      pulse_clr(); cnt = 0;
      for (int c = 0; c < 2500; c++) begin
        logic t;
        osc_tick = ($urandom_range(0, 1) == 1);
        rtc_tick = ($urandom_range(0, 1) == 1);
        clr = ($urandom_range(0, 299) == 0);
        t = (src_sel == 0) ? osc_tick : rtc_tick;
        exp_rst = 0;
        if (clr) cnt = 0;
        else if (t) begin
          cnt++;
          if (cnt == lim) begin exp_rst = 1; cnt = 0; end
        end
        @(posedge clk); @(negedge clk);
        if (wdt_rst != exp_rst) chk("R4 random traffic", wdt_rst, exp_rst);
      end
      osc_tick = 0; rtc_tick = 0; clr = 0;
      chk("R5 random block end", 1, 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule